// File: doc/BRIEF.md
# Priority Threshold Target Arbiter

This block picks, for a single interrupt target, which source the target should service next. Each cycle it looks at a vector of pending flags, the target's per-source enable mask, one priority value per source and the target's threshold. From the sources that are both pending and enabled, it selects the one with the largest priority. When two or more sources share the top value, the lowest-numbered source wins. The number of the winner is presented as the claim ID. ID 0 means that no source is ready.

A separate request line tells the target to take an interrupt. It is raised only when the winner's priority is strictly above the threshold. The claim ID does not depend on the threshold, so a read of the ID can still return a source that is too weak to raise the request. Edge and level capture, register storage, bus decoding and the claim and complete sequencing all sit outside this block. Several copies of the block, one per target, can share one pending vector and one priority array.

The selection is a balanced tree of compare-select nodes. The results pass through an optional output register, which is enabled by default.

Top module: `prio_thresh_arbiter`

## Requirements
- R1: A source's ID is its bit position in `pend_i`. Bit 0 is reserved: it never takes part, whatever its pending, enable or priority value, and ID 0 on `claim_id_o` means "none".
- R2: Among the sources with bits 1 and up that are both pending and enabled, `claim_id_o` is the one with the largest priority. Source i's priority is `prio_i[i*PW +: PW]`.
- R3: When several pending, enabled sources share the largest priority, `claim_id_o` is the lowest ID among them.
- R4: A source whose enable bit is 0 never appears on `claim_id_o` and never causes `irq_o`, even when its priority is higher than every enabled source.
- R5: When no source with bit 1 or above is both pending and enabled, `claim_id_o` is 0 and `irq_o` is 0.
- R6: `irq_o` is 1 exactly when a winner exists and its priority is strictly greater than `thresh_i`. A priority equal to the threshold does not raise it.
- R7: `claim_id_o` does not depend on `thresh_i`. A winner at or below the threshold is still presented while `irq_o` stays 0.
- R8: A winner with priority 0 never raises `irq_o`. A threshold of all ones (the maximum priority) keeps `irq_o` at 0 for every input pattern.
- R9: With `OUT_REG` = 1, both outputs reflect the inputs sampled at the previous rising clock edge. While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low reset; clears the outputs |
| pend_i | input | NSRC | Pending flag per source; bit 0 is tied low externally |
| en_i | input | NSRC | This target's enable mask, one bit per source |
| prio_i | input | NSRC*PW | Priority per source, source i in bits [i*PW +: PW] |
| thresh_i | input | PW | This target's priority threshold |
| claim_id_o | output | $clog2(NSRC) | ID of the winning source, 0 if none |
| irq_o | output | 1 | Interrupt request to the target |

## Verification
The bench goes after the following corner cases:
- **Ties at the top priority.** A node that lets its right operand win on equal values would present the highest tied ID instead of the lowest.
- **Threshold equal to the winner's priority.** Here `irq_o` must stay low. A design using greater-or-equal would fire, including for priority-0 winners when the threshold is 0.
- **A disabled source above every enabled one.** This exposes a mask applied after the search rather than before it: the ID would drop to 0 or name the disabled source.
- **A winner below the threshold.** A design that wrongly gated the ID with the threshold would return 0 here.

Random patterns are then checked against a loop over all sources. Each step also checks that the outputs still hold the previous result just after the inputs change, which catches a missing or doubled output stage.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int unsigned DEF_NSRC = 32;
    localparam int unsigned DEF_PW   = 3;

    // Width of a source ID for a given number of sources (at least 1 bit).
    function automatic int unsigned id_width(input int unsigned nsrc);
        return (nsrc < 2) ? 1 : $clog2(nsrc);
    endfunction

endpackage

// File: rtl/prio_arb_node.sv
// One compare-select step: the lower-ID operand (left) keeps the slot
// unless the right operand is valid with a strictly larger priority.
module prio_arb_node #(
    parameter int unsigned PW  = 3,
    parameter int unsigned IDW = 5
) (
    input  logic           l_vld,
    input  logic [PW-1:0]  l_prio,
    input  logic [IDW-1:0] l_id,
    input  logic           r_vld,
    input  logic [PW-1:0]  r_prio,
    input  logic [IDW-1:0] r_id,
    output logic           o_vld,
    output logic [PW-1:0]  o_prio,
    output logic [IDW-1:0] o_id
);

    logic take_right;

    always_comb begin
        take_right = r_vld && (!l_vld || (r_prio > l_prio));
        o_vld      = l_vld || r_vld;
        o_prio     = take_right ? r_prio : l_prio;
        o_id       = take_right ? r_id   : l_id;
    end

endmodule

// File: rtl/prio_arb_tree.sv
// Balanced search tree stored heap-style: node k has children 2k and 2k+1,
// leaves occupy LEAVES .. 2*LEAVES-1 in ID order, the root is node 1.
module prio_arb_tree #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 3,
    parameter int unsigned IDW  = 5
) (
    input  logic [NSRC-1:0]    pend,
    input  logic [NSRC-1:0]    en,
    input  logic [NSRC*PW-1:0] prio,
    output logic               root_vld,
    output logic [PW-1:0]      root_prio,
    output logic [IDW-1:0]     root_id
);

    localparam int unsigned LEAVES = 1 << IDW;
    localparam int unsigned NODES  = 2 * LEAVES;

    logic           vld_w  [1:NODES-1];
    logic [PW-1:0]  prio_w [1:NODES-1];
    logic [IDW-1:0] id_w   [1:NODES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NSRC) begin : g_real
            // ID 0 is reserved and never competes.
            assign vld_w[LEAVES+i]  = (i != 0) && pend[i] && en[i];
            assign prio_w[LEAVES+i] = prio[i*PW +: PW];
        end else begin : g_pad
            assign vld_w[LEAVES+i]  = 1'b0;
            assign prio_w[LEAVES+i] = '0;
        end
        assign id_w[LEAVES+i] = IDW'(i);
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        prio_arb_node #(
            .PW  (PW),
            .IDW (IDW)
        ) i_node (
            .l_vld  (vld_w[2*k]),
            .l_prio (prio_w[2*k]),
            .l_id   (id_w[2*k]),
            .r_vld  (vld_w[2*k+1]),
            .r_prio (prio_w[2*k+1]),
            .r_id   (id_w[2*k+1]),
            .o_vld  (vld_w[k]),
            .o_prio (prio_w[k]),
            .o_id   (id_w[k])
        );
    end

    assign root_vld  = vld_w[1];
    assign root_prio = prio_w[1];
    assign root_id   = id_w[1];

endmodule

// File: rtl/prio_arb_notify.sv
// Request decision: strict greater-than against the target threshold.
module prio_arb_notify #(
    parameter int unsigned PW = 3
) (
    input  logic          win_vld,
    input  logic [PW-1:0] win_prio,
    input  logic [PW-1:0] thresh,
    output logic          req
);

    always_comb begin
        req = win_vld && (win_prio > thresh);
    end

endmodule

// File: rtl/prio_thresh_arbiter.sv
module prio_thresh_arbiter
    import prio_arb_pkg::*;
#(
    parameter int unsigned NSRC    = DEF_NSRC,
    parameter int unsigned PW      = DEF_PW,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned IDW    = id_width(NSRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC-1:0]    en_i,
    input  logic [NSRC*PW-1:0] prio_i,
    input  logic [PW-1:0]      thresh_i,
    output logic [IDW-1:0]     claim_id_o,
    output logic               irq_o
);

    localparam logic [PW-1:0] MAXP = '1;

    typedef struct packed {
        logic [IDW-1:0] id;
        logic           irq;
    } arb_out_t;

    logic           root_vld;
    logic [PW-1:0]  root_prio;
    logic [IDW-1:0] root_id;
    logic           notify;

    arb_out_t out_d, out_q;

    prio_arb_tree #(
        .NSRC (NSRC),
        .PW   (PW),
        .IDW  (IDW)
    ) i_tree (
        .pend      (pend_i),
        .en        (en_i),
        .prio      (prio_i),
        .root_vld  (root_vld),
        .root_prio (root_prio),
        .root_id   (root_id)
    );

    prio_arb_notify #(
        .PW (PW)
    ) i_notify (
        .win_vld  (root_vld),
        .win_prio (root_prio),
        .thresh   (thresh_i),
        .req      (notify)
    );

    always_comb begin
        out_d     = '0;
        out_d.id  = root_vld ? root_id : '0;
        out_d.irq = notify;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= '0;
            else         out_q <= out_d;
        end

        // Checker state: which sources were live at the last sampling edge.
        logic [NSRC-1:0] live_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) live_q <= '0;
            else         live_q <= pend_i & en_i & ~NSRC'(1);
        end

        // R4
        winner_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (claim_id_o != '0) |-> live_q[claim_id_o]);

        // R5
        empty_id_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((pend_i & en_i & ~NSRC'(1)) == '0) |=> (claim_id_o == '0 && !irq_o));

        // R8
        max_thresh_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (thresh_i == MAXP) |=> !irq_o);

        // R6
        irq_has_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o |-> (claim_id_o != '0));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign claim_id_o = out_q.id;
    assign irq_o      = out_q.irq;

endmodule

// File: tb/test_prio_thresh_arbiter.sv
module test_prio_thresh_arbiter;

    localparam int unsigned N   = 32;
    localparam int unsigned PW  = 3;
    localparam int unsigned IDW = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       pend = '0;
    logic [N-1:0]       en = '0;
    logic [N*PW-1:0]    prio = '0;
    logic [PW-1:0]      thresh = '0;
    logic [IDW-1:0]     claim_id;
    logic               irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [IDW-1:0] prev_id  = '0;
    logic           prev_irq = 1'b0;

    always #5 clk = ~clk;

    prio_thresh_arbiter #(
        .NSRC (N),
        .PW   (PW)
    ) i_prio_thresh_arbiter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pend_i     (pend),
        .en_i       (en),
        .prio_i     (prio),
        .thresh_i   (thresh),
        .claim_id_o (claim_id),
        .irq_o      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference: scan every source, keep the first one with the largest priority.
    task automatic ref_model(input logic [N-1:0] p, input logic [N-1:0] e,
                             input logic [N*PW-1:0] pr, input logic [PW-1:0] t,
                             output logic [IDW-1:0] id, output logic rq);
        int best = 0;
        int bp = 0;
        for (int i = 1; i < N; i++) begin
            if (p[i] && e[i]) begin
                if (best == 0 || int'(pr[i*PW +: PW]) > bp) begin
                    best = i;
                    bp = int'(pr[i*PW +: PW]);
                end
            end
        end
        id = IDW'(best);
        rq = (best != 0) && (bp > int'(t));
    endtask

    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N*PW-1:0] pr, input logic [PW-1:0] t,
                         input string tag);
        logic [IDW-1:0] eid;
        logic           eirq;
        @(negedge clk);
        pend = p; en = e; prio = pr; thresh = t;
        #1;
        check("R9 id held before edge", 32'(claim_id), 32'(prev_id));
        check("R9 irq held before edge", 32'(irq), 32'(prev_irq));
        ref_model(p, e, pr, t, eid, eirq);
        @(negedge clk);
        check({tag, " id"}, 32'(claim_id), 32'(eid));
        check({tag, " irq"}, 32'(irq), 32'(eirq));
        prev_id = eid;
        prev_irq = eirq;
    endtask

    function automatic logic [N*PW-1:0] setp(input logic [N*PW-1:0] pr, input int idx,
                                             input int val);
        logic [N*PW-1:0] r = pr;
        r[idx*PW +: PW] = PW'(val);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*PW-1:0] pr;
        void'($urandom(32'd20240611));

        // Reset state, with inputs that would otherwise raise a request.
        pend = 32'h0000_0010; en = 32'h0000_0010; prio = setp('0, 4, 7);
        repeat (3) @(negedge clk);
        check("R9 reset id", 32'(claim_id), 0);
        check("R9 reset irq", 32'(irq), 0);
        pend = '0; en = '0; prio = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R5: nothing live.
        apply('0, '0, '0, '0, "R5 empty");
        // R1: only bit 0 live, at top priority.
        apply(32'h1, 32'h1, setp('0, 0, 7), 3'd0, "R1 bit0 ignored");
        // R2: largest priority wins.
        pr = setp(setp(setp('0, 3, 2), 9, 5), 20, 4);
        apply(32'h0010_0208, 32'hFFFF_FFFF, pr, 3'd1, "R2 max prio");
        // R3: three-way tie at 4, lowest ID 6.
        pr = setp(setp(setp('0, 30, 4), 12, 4), 6, 4);
        apply(32'h4000_1040, 32'h4000_1040, pr, 3'd0, "R3 tie lowest");
        // R4: disabled source 9 at prio 7 above enabled source 3 at prio 2.
        pr = setp(setp('0, 9, 7), 3, 2);
        apply(32'h0000_0208, 32'h0000_0008, pr, 3'd1, "R4 disabled skipped");
        // R6: winner equal to threshold, then one above.
        apply(32'h0000_0208, 32'h0000_0008, pr, 3'd2, "R6 equal no irq");
        pr = setp('0, 17, 5);
        apply(32'h0002_0000, 32'h0002_0000, pr, 3'd5, "R6 equal5 no irq");
        apply(32'h0002_0000, 32'h0002_0000, pr, 3'd4, "R6 above irq");
        // R7: winner below threshold still presented.
        pr = setp('0, 25, 2);
        apply(32'h0200_0000, 32'h0200_0000, pr, 3'd6, "R7 below thresh id");
        // R8: priority-0 winner, and maximum threshold.
        apply(32'h0000_0800, 32'h0000_0800, '0, 3'd0, "R8 prio0 no irq");
        pr = setp('0, 31, 7);
        apply(32'h8000_0000, 32'h8000_0000, pr, 3'd7, "R8 max thresh");
        // R4: everything pending, nothing enabled.
        apply(32'hFFFF_FFFE, '0, {N*PW{1'b1}}, 3'd0, "R4 all disabled");

        // Random patterns, mixing dense and sparse masks.
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0]    rp;
            logic [N-1:0]    re;
            logic [N*PW-1:0] rpr;
            rp = $urandom;
            re = $urandom;
            if (n % 3 == 1) rp = rp & $urandom & $urandom;
            if (n % 5 == 2) re = '1;
            for (int i = 0; i < N; i++) rpr[i*PW +: PW] = PW'($urandom_range(0, (1 << PW) - 1));
            if (n % 7 == 3) rpr = {N{rpr[PW-1:0]}};
            apply(rp, re, rpr, PW'($urandom_range(0, (1 << PW) - 1)), "R2 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule